// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a short burst. A load cycle captures a full start address. Each later advance cycle steps the low-order address bits through the burst, and the upper bits keep the value they had at the load. After the last beat the sequence returns to the start address and repeats for as long as advance stays asserted.

A static mode pin selects the beat order. With the pin low the order is linear: the low bits count upward from the start and wrap modulo the burst length. With the pin high the order is interleaved: beat k uses the start's low bits XORed with k. An active-high hold input freezes the block completely, and while it is high the load and advance inputs are ignored. The memory array and the data path are not part of this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset (rst_n low) is asserted and after it is released, addr_out is zero until the first load.
- R2: A cycle with hold low and load high captures start_addr. After that rising edge, addr_out equals start_addr.
- R3: A cycle with hold low, load low and advance high moves the burst position forward by one beat at that rising edge.
- R4: With interleave low (linear order), the low two address bits at position k equal (s + k) mod 4, where s is the low two bits of the loaded address.
- R5: With interleave high (interleaved order), the low two address bits at position k equal s XOR k. From 01 this gives 01, 00, 11, 10.
- R6: An advance after the fourth beat returns addr_out to the loaded start address, and the sequence repeats.
- R7: While hold is high, addr_out does not change, and load, advance and start_addr have no effect.
- R8: Advance cycles never change address bits above the low two. Those bits keep their value from the last load.
- R9: A load in the middle of a burst drops the old burst and restarts at position zero from the new address.
- R10: When load and advance are both high with hold low, the load takes priority. addr_out becomes start_addr at position zero.
- R11: A cycle with hold, load and advance all low leaves addr_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | High freezes all state and makes load and advance have no effect |
| load | input | 1 | Captures start_addr and restarts the burst |
| advance | input | 1 | Steps to the next beat of the burst |
| interleave | input | 1 | Static order select: 0 linear, 1 interleaved |
| start_addr | input | ADDR_W | Full start address captured on load |
| addr_out | output | ADDR_W | Current beat address |

## Verification
The block has a single register stage. Every result caused by the inputs applied in a cycle appears on addr_out just after the next rising edge, and the mode pin affects the output combinationally. The bench's driver applies each stimulus at a falling edge and pushes the address the requirements predict for it. The monitor pops that entry 5 ns after the following rising edge, which is exactly one register stage later and well clear of any edge. Hold, idle and wrap cases are checked in the same way: the bench compares the predicted unchanged or repeated address at the same slot.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Decoded per-cycle action, resolved with hold and priority applied
  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_STEP = 2'd2
  } burst_cmd_e;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_cmd_dec.sv
module burst_cmd_dec
  import burst_pkg::*;
(
  input  logic       hold,
  input  logic       load,
  input  logic       advance,
  output burst_cmd_e cmd
);

  // hold masks everything; load outranks advance
  always_comb begin
    if (hold)         cmd = CMD_IDLE;
    else if (load)    cmd = CMD_LOAD;
    else if (advance) cmd = CMD_STEP;
    else              cmd = CMD_IDLE;
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  burst_cmd_e        cmd,
  output logic [BEAT_W-1:0] beat,
  output logic              wrap_evt
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

  function automatic logic [BEAT_W-1:0] next_beat(input logic [BEAT_W-1:0] b);
    return b + BEAT_W'(1);
  endfunction

  assign wrap_evt = (cmd == CMD_STEP) && (beat == LAST_BEAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat <= '0;
    end else begin
      unique case (cmd)
        CMD_LOAD: beat <= '0;
        CMD_STEP: beat <= next_beat(beat);
        default:  beat <= beat;
      endcase
    end
  end

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  burst_cmd_e        cmd,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] base
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               base <= '0;
    else if (cmd == CMD_LOAD) base <= start_addr;
  end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  burst_order_e      order,
  input  logic [BEAT_W-1:0] start_low,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] low
);

  logic [BEAT_W-1:0] ilv_low;

  function automatic logic [BEAT_W-1:0] linear_pos(
    input logic [BEAT_W-1:0] s, input logic [BEAT_W-1:0] k);
    return s + k;
  endfunction

  // interleaved order: each bit toggles with the matching beat bit
  for (genvar g = 0; g < BEAT_W; g++) begin : g_ilv
    assign ilv_low[g] = start_low[g] ^ beat[g];
  end

  always_comb begin
    if (order == ORDER_INTERLEAVE) low = ilv_low;
    else                           low = linear_pos(start_low, beat);
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              load,
  input  logic              advance,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] addr_out
);

  localparam int UPPER_W = ADDR_W - BEAT_W;

  burst_cmd_e        cmd;
  logic [BEAT_W-1:0] beat;
  logic              wrap_evt;
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] low;
  burst_order_e      order;

  assign order = burst_order_e'(interleave);

  burst_cmd_dec u_dec (
    .hold    (hold),
    .load    (load),
    .advance (advance),
    .cmd     (cmd)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .beat     (beat),
    .wrap_evt (wrap_evt)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .start_addr (start_addr),
    .base       (base)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order     (order),
    .start_low (base[BEAT_W-1:0]),
    .beat      (beat),
    .low       (low)
  );

  assign addr_out = {base[ADDR_W-1 -: UPPER_W], low};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold,
  input logic              load,
  input logic              advance,
  input logic              interleave,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] addr_out,
  input logic [BEAT_W-1:0] beat,
  input logic              wrap_evt,
  input logic [ADDR_W-1:0] base
);

  // R1
  a_r1_reset_zero: assert property (@(posedge clk) !rst_n |-> addr_out == '0);

  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !hold && load |=> addr_out == $past(start_addr));

  a_r3_step_beat: assert property (@(posedge clk) disable iff (!rst_n)
    !hold && !load && advance |=> beat == $past(beat) + BEAT_W'(1));

  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    !hold && !load && advance && !interleave ##1 !interleave
    |-> addr_out[BEAT_W-1:0] == $past(addr_out[BEAT_W-1:0]) + BEAT_W'(1));

  a_r5_interleave_step: assert property (@(posedge clk) disable iff (!rst_n)
    !hold && !load && advance && interleave ##1 interleave
    |-> (addr_out[BEAT_W-1:0] ^ $past(addr_out[BEAT_W-1:0])) == (beat ^ $past(beat)));

  a_r6_wrap_home: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> addr_out == base && beat == '0);

  a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    hold && $stable(interleave) ##1 $stable(interleave) |-> $stable(addr_out));

  a_r8_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

  a_r9_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !hold && load |=> beat == '0);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hold && !load && !advance ##1 $stable(interleave) |-> $stable(addr_out));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hold       (hold),
  .load       (load),
  .advance    (advance),
  .interleave (interleave),
  .start_addr (start_addr),
  .addr_out   (addr_out),
  .beat       (beat),
  .wrap_evt   (wrap_evt),
  .base       (base)
);

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;

  localparam int ADDR_W = 16;
  localparam int BEAT_W = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              hold = 1'b0;
  logic              load = 1'b0;
  logic              advance = 1'b0;
  logic              interleave = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [ADDR_W-1:0] addr_out;

  int checks = 0;
  int errors = 0;

  logic [ADDR_W-1:0] exp_q[$];
  string             tag_q[$];

  // reference model state
  logic [ADDR_W-1:0] m_base = '0;
  int                m_pos  = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_burst_addr_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .load       (load),
    .advance    (advance),
    .interleave (interleave),
    .start_addr (start_addr),
    .addr_out   (addr_out)
  );

  function automatic logic [ADDR_W-1:0] predict(input logic mode);
    logic [1:0] s;
    logic [1:0] k;
    logic [1:0] lo;
    s  = m_base[1:0];
    k  = 2'(m_pos);
    lo = mode ? (s ^ k) : 2'((int'(s) + m_pos) % 4);
    return {m_base[ADDR_W-1:2], lo};
  endfunction

  task automatic check(input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp,
                       input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: addr_out=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus at the falling edge, queue the prediction
  task automatic drive(input logic h, input logic ld, input logic adv, input logic mode,
                       input logic [ADDR_W-1:0] a, input string tag);
    @(negedge clk);
    hold = h; load = ld; advance = adv; interleave = mode; start_addr = a;
    if (!h) begin
      if (ld) begin
        m_base = a;
        m_pos  = 0;
      end else if (adv) begin
        m_pos = (m_pos + 1) % 4;
      end
    end
    exp_q.push_back(predict(mode));
    tag_q.push_back(tag);
  endtask

  // monitor: compare one register stage later, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) check(addr_out, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog: addr_out=%h expected=run complete", addr_out);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 check(addr_out, '0, "R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #5 check(addr_out, '0, "R1 after reset");

    // linear order from low bits 01, with wrap
    drive(0, 1, 0, 0, 16'hABC5, "R2 load linear");
    drive(0, 0, 1, 0, 16'h0000, "R3 R4 linear beat1");
    drive(0, 0, 1, 0, 16'hFFFF, "R4 R8 linear beat2");
    drive(0, 0, 1, 0, 16'h1234, "R4 linear beat3");
    drive(0, 0, 1, 0, 16'h0000, "R6 linear wrap");
    drive(0, 0, 1, 0, 16'h0000, "R6 linear repeat");

    // interleaved from 01: 01,00,11,10,01
    drive(0, 1, 0, 1, 16'h1235, "R2 load interleaved");
    drive(0, 0, 1, 1, 16'h0000, "R5 ilv beat1");
    drive(0, 0, 1, 1, 16'h0000, "R5 ilv beat2");
    drive(0, 0, 1, 1, 16'h0000, "R5 R8 ilv beat3");
    drive(0, 0, 1, 1, 16'h0000, "R6 ilv wrap");

    // interleaved from 10
    drive(0, 1, 0, 1, 16'h00FA, "R2 load ilv 10");
    drive(0, 0, 1, 1, 16'h0000, "R5 ilv from 10 beat1");
    drive(0, 0, 1, 1, 16'h0000, "R5 ilv from 10 beat2");

    // hold: load/advance/start ignored
    drive(1, 1, 1, 1, 16'h5555, "R7 hold with load");
    drive(1, 0, 1, 1, 16'h7777, "R7 hold with advance");
    drive(0, 0, 1, 1, 16'h0000, "R7 resume after hold");

    // idle cycle
    drive(0, 0, 0, 1, 16'h9999, "R11 idle");

    // linear from 11, then reload mid-burst
    drive(0, 1, 0, 0, 16'h3C0F, "R2 load linear 11");
    drive(0, 0, 1, 0, 16'h0000, "R4 linear 11 beat1");
    drive(0, 1, 0, 0, 16'h4442, "R9 reload mid-burst");
    drive(0, 0, 1, 0, 16'h0000, "R9 restart beat1");

    // load and advance together
    drive(0, 0, 1, 0, 16'h0000, "R3 advance");
    drive(0, 1, 1, 0, 16'h8001, "R10 load wins");
    drive(0, 0, 1, 0, 16'h0000, "R10 beat1 after load");

    drive(0, 0, 0, 0, 16'h0000, "R11 final idle");
    repeat (3) @(posedge clk);
    #5;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule